// File: doc/BRIEF.md
# Double-Buffered Piecewise-Linear Degamma Curve

This block turns non-linear 12-bit pixel codes into linear light, one colour channel at a time. It holds two curve memories. One of them can drive the pixel path while software refills the other through a small load port. The 12-bit input code is split in two. The upper six bits pick one of 64 curve points. The lower six bits are a fraction used to interpolate between that point and the next. Each stored point keeps a base value and a slope per channel. Besides the two memories, the block offers a pass-through mode and two built-in fixed curves that use the same point format.

Software chooses a curve by writing a mode code. The choice only takes effect on a frame-start strobe, so a curve never changes in the middle of a frame. A small status code tells software which memory is live, so it knows which one it may refill. A memory power-down input marks lookups from memory as invalid.

The load port is run by a six-phase sequencer. Its states are PH_RBASE, PH_GBASE, PH_BBASE, PH_RSLOPE, PH_GSLOPE and PH_BSLOPE.
- An index write moves it to PH_RBASE at the given point.
- Each data write moves it to the next phase.
- The step from PH_BSLOPE back to PH_RBASE also advances the point.

The committed curve is a second state register with five named states: MD_PASS, MD_CURVE1, MD_CURVE2, MD_RAMA and MD_RAMB. It moves only on a frame-start strobe, to the state named by the mode code. It resets to MD_PASS.

Top module: `dgam_pingpong`

## Requirements
- R1: After reset the committed mode is pass-through, `lut_stat` is 0, and `out_vld`, `out_ok` and all three outputs are 0.
- R2: Mode codes 0, 5, 6 and 7 pass each input channel to its output unchanged.
- R3: Mode code 1 uses a built-in curve with base p*p and slope 2p+1 at point p. Mode code 2 uses a built-in curve with base floor(p*p*p/64) and slope base(p+1)-base(p).
- R4: Each channel is computed as follows:
  - point p = in[11:6] and fraction f = in[5:0];
  - result = base(p) + floor(slope(p)*f/64);
  - a result above 4095 is clamped to 4095.
- R5: A pixel presented with `pix_vld` high at one rising edge appears on the outputs with `out_vld` high right after the second rising edge after it. `out_vld` is high for exactly one cycle per input pixel.
- R6: The index write and the data port work together as follows:
  - an index write (`idx_wr`) sets the load pointer and restarts the word order;
  - data words then go to red base, green base, blue base, red slope, green slope and blue slope, in that order;
  - after the sixth word the pointer steps to the next point, wrapping from 63 to 0;
  - if an index write and a data write occur in the same cycle, the data write is dropped.
- R7: `wr_sel` picks the memory being loaded: 0 for memory A, 1 for memory B. `wr_mask` bit 0 enables red, bit 1 green and bit 2 blue. A masked word is not stored, but the word order still advances.
- R8: A data word aimed at the memory that is currently committed (mode 3 with `wr_sel`=0, or mode 4 with `wr_sel`=1) is discarded, but the word order still advances.
- R9: The status and the curve both follow the committed mode:
  - `cfg_mode` is committed only at a rising edge where `frame_start` is high;
  - `lut_stat` reads 9 while memory A (code 3) is committed, 10 while memory B (code 4) is committed, and 0 otherwise;
  - `lut_stat` changes only at such an edge.
- R10: Some pixels cannot be looked up. This applies to a pixel sampled while `mem_off` is 1 and a memory mode (3 or 4) is committed. Such a pixel comes out with `out_ok` 0 and all channels 0. Every other pixel comes out with `out_ok` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Commits `cfg_mode` at this edge |
| cfg_mode | input | 3 | Requested curve: 0 pass, 1/2 built-in curves, 3 memory A, 4 memory B |
| mem_off | input | 1 | Curve memory powered down; memory lookups invalid |
| idx_wr | input | 1 | Load pointer write strobe |
| idx_val | input | 6 | New load pointer |
| dat_wr | input | 1 | Data port write strobe |
| dat_val | input | 12 | Data word |
| wr_sel | input | 1 | Memory being loaded: 0 A, 1 B |
| wr_mask | input | 3 | Per-channel write enable (bit 0 red, 1 green, 2 blue) |
| lut_stat | output | 4 | 9 = memory A live, 10 = memory B live, else 0 |
| pix_vld | input | 1 | Input pixel valid |
| pix_r | input | 12 | Red input code |
| pix_g | input | 12 | Green input code |
| pix_b | input | 12 | Blue input code |
| out_vld | output | 1 | Output pixel valid |
| out_ok | output | 1 | Output pixel came from a valid lookup |
| out_r | output | 12 | Red linear result |
| out_g | output | 12 | Green linear result |
| out_b | output | 12 | Blue linear result |

## Verification
A pixel result is due two rising edges after the edge that samples `pix_vld`. The bench drives each pixel on a falling edge. It checks at the falling edge after the first rise that `out_vld` is still low. It reads the result at the falling edge after the second rise. A change of mode or status is due one edge after the frame-start strobe and is read at the next falling edge. A load word is stored at its own edge, so the effect of a load is checked through pixels sent after the last word. The expected value is computed from the mode, the `mem_off` level and the bench's own copy of the curve points, all taken at the time the pixel is driven.

// File: rtl/dgam_pkg.sv
package dgam_pkg;

    localparam int NCH  = 3;
    localparam int NRAM = 2;

    typedef enum logic [2:0] {
        MD_PASS   = 3'd0,
        MD_CURVE1 = 3'd1,
        MD_CURVE2 = 3'd2,
        MD_RAMA   = 3'd3,
        MD_RAMB   = 3'd4
    } mode_e;

    typedef enum logic [2:0] {
        PH_RBASE  = 3'd0,
        PH_GBASE  = 3'd1,
        PH_BBASE  = 3'd2,
        PH_RSLOPE = 3'd3,
        PH_GSLOPE = 3'd4,
        PH_BSLOPE = 3'd5
    } phase_e;

    // Built-in curves: square law, or cube law scaled down by one point width.
    function automatic int curve_base(input logic cubic, input int p, input int pbits);
        if (cubic)
            return (p * p * p) >> pbits;
        return p * p;
    endfunction

    function automatic int curve_step(input logic cubic, input int p, input int pbits);
        return curve_base(cubic, p + 1, pbits) - curve_base(cubic, p, pbits);
    endfunction

endpackage

// File: rtl/dgam_loader.sv
module dgam_loader
    import dgam_pkg::*;
#(
    parameter int PT_BITS = 6,
    parameter int DW      = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idx_wr,
    input  logic [PT_BITS-1:0] idx_val,
    input  logic               dat_wr,
    input  logic [DW-1:0]      dat_val,
    input  logic               wr_sel,
    input  logic [NCH-1:0]     wr_mask,
    input  mode_e              live_mode,
    output logic [NCH-1:0]     w_chv,
    output logic               w_ram,
    output logic               w_slope,
    output logic [PT_BITS-1:0] w_addr,
    output logic [DW-1:0]      w_data
);

    phase_e             phase;
    phase_e             phase_nx;
    logic [PT_BITS-1:0] ptr;
    logic [1:0]         ch;
    logic               slope;
    logic               guarded;
    logic               take;

    // Next word in the fixed order; the last slope word returns to the first base.
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_RBASE:  phase_nx = PH_GBASE;
            PH_GBASE:  phase_nx = PH_BBASE;
            PH_BBASE:  phase_nx = PH_RSLOPE;
            PH_RSLOPE: phase_nx = PH_GSLOPE;
            PH_GSLOPE: phase_nx = PH_BSLOPE;
            PH_BSLOPE: phase_nx = PH_RBASE;
        endcase
    end

    // State register: an index write wins over a data write in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_RBASE;
            ptr   <= '0;
        end else if (idx_wr) begin
            phase <= PH_RBASE;
            ptr   <= idx_val;
        end else if (dat_wr) begin
            phase <= phase_nx;
            if (phase == PH_BSLOPE)
                ptr <= ptr + 1'b1;
        end
    end

    // Outputs: decode the word target; drop writes to the live memory.
    always_comb begin
        ch    = 2'd0;
        slope = 1'b0;
        unique case (phase)
            PH_RBASE:  begin ch = 2'd0; slope = 1'b0; end
            PH_GBASE:  begin ch = 2'd1; slope = 1'b0; end
            PH_BBASE:  begin ch = 2'd2; slope = 1'b0; end
            PH_RSLOPE: begin ch = 2'd0; slope = 1'b1; end
            PH_GSLOPE: begin ch = 2'd1; slope = 1'b1; end
            PH_BSLOPE: begin ch = 2'd2; slope = 1'b1; end
        endcase
        guarded = (live_mode == MD_RAMA && !wr_sel) || (live_mode == MD_RAMB && wr_sel);
        take    = dat_wr && !idx_wr && !guarded;
        w_chv   = '0;
        if (take && wr_mask[ch])
            w_chv[ch] = 1'b1;
        w_ram   = wr_sel;
        w_slope = slope;
        w_addr  = ptr;
        w_data  = dat_val;
    end

endmodule

// File: rtl/dgam_store.sv
module dgam_store
    import dgam_pkg::*;
#(
    parameter int PT_BITS = 6,
    parameter int DW      = 12
) (
    input  logic                                clk,
    input  logic [NCH-1:0]                      w_chv,
    input  logic                                w_ram,
    input  logic                                w_slope,
    input  logic [PT_BITS-1:0]                  w_addr,
    input  logic [DW-1:0]                       w_data,
    input  logic [NCH-1:0][PT_BITS-1:0]         rd_pt,
    output logic [NRAM-1:0][NCH-1:0][DW-1:0]    rd_base,
    output logic [NRAM-1:0][NCH-1:0][DW-1:0]    rd_slope
);

    localparam int NPT = 1 << PT_BITS;

    for (genvar r = 0; r < NRAM; r++) begin : g_ram
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic [DW-1:0] base_q  [NPT];
            logic [DW-1:0] slope_q [NPT];

            always_ff @(posedge clk) begin
                if (w_chv[c] && (int'(w_ram) == r)) begin
                    if (w_slope)
                        slope_q[w_addr] <= w_data;
                    else
                        base_q[w_addr] <= w_data;
                end
            end

            assign rd_base[r][c]  = base_q[rd_pt[c]];
            assign rd_slope[r][c] = slope_q[rd_pt[c]];
        end
    end

endmodule

// File: rtl/dgam_eval.sv
module dgam_eval
    import dgam_pkg::*;
#(
    parameter int PT_BITS = 6,
    parameter int FR_BITS = 6
) (
    input  logic                                                clk,
    input  logic                                                rst_n,
    input  logic                                                pix_vld,
    input  logic [NCH-1:0][PT_BITS+FR_BITS-1:0]                 pix_in,
    input  mode_e                                               live_mode,
    input  logic                                                mem_off,
    input  logic [NRAM-1:0][NCH-1:0][PT_BITS+FR_BITS-1:0]       rd_base,
    input  logic [NRAM-1:0][NCH-1:0][PT_BITS+FR_BITS-1:0]       rd_slope,
    output logic                                                out_vld,
    output logic                                                out_ok,
    output logic [NCH-1:0][PT_BITS+FR_BITS-1:0]                 out_px
);

    localparam int DW = PT_BITS + FR_BITS;

    logic use_mem;
    logic s1_vld;
    logic s1_pass;
    logic s1_bad;

    assign use_mem = (live_mode == MD_RAMA) || (live_mode == MD_RAMB);

    // Shared control of both stages.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_pass <= 1'b1;
            s1_bad  <= 1'b0;
            out_vld <= 1'b0;
            out_ok  <= 1'b0;
        end else begin
            s1_vld  <= pix_vld;
            s1_pass <= !(use_mem || live_mode == MD_CURVE1 || live_mode == MD_CURVE2);
            s1_bad  <= mem_off && use_mem;
            out_vld <= s1_vld;
            out_ok  <= s1_vld && !s1_bad;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [PT_BITS-1:0]    pt;
        logic [DW-1:0]         lk_base;
        logic [DW-1:0]         lk_slope;
        logic [DW-1:0]         s1_in;
        logic [DW-1:0]         s1_base;
        logic [DW-1:0]         s1_slope;
        logic [FR_BITS-1:0]    s1_fr;
        logic [DW+FR_BITS-1:0] prod;
        logic [DW:0]           sum;
        logic [DW-1:0]         sat;
        logic [DW-1:0]         out_q;

        assign pt = pix_in[c][DW-1 -: PT_BITS];

        // Stage 1 lookup: built-in curve, live memory, or nothing.
        always_comb begin
            unique case (live_mode)
                MD_CURVE1: begin
                    lk_base  = DW'(curve_base(1'b0, int'(pt), PT_BITS));
                    lk_slope = DW'(curve_step(1'b0, int'(pt), PT_BITS));
                end
                MD_CURVE2: begin
                    lk_base  = DW'(curve_base(1'b1, int'(pt), PT_BITS));
                    lk_slope = DW'(curve_step(1'b1, int'(pt), PT_BITS));
                end
                MD_RAMA: begin
                    lk_base  = rd_base[0][c];
                    lk_slope = rd_slope[0][c];
                end
                MD_RAMB: begin
                    lk_base  = rd_base[1][c];
                    lk_slope = rd_slope[1][c];
                end
                default: begin
                    lk_base  = '0;
                    lk_slope = '0;
                end
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_in    <= '0;
                s1_base  <= '0;
                s1_slope <= '0;
                s1_fr    <= '0;
                out_q    <= '0;
            end else begin
                s1_in    <= pix_in[c];
                s1_base  <= lk_base;
                s1_slope <= lk_slope;
                s1_fr    <= pix_in[c][FR_BITS-1:0];
                out_q    <= s1_bad ? '0 : (s1_pass ? s1_in : sat);
            end
        end

        // Stage 2: base plus scaled slope, clamped to full scale.
        assign prod = {{FR_BITS{1'b0}}, s1_slope} * {{DW{1'b0}}, s1_fr};
        assign sum  = {1'b0, s1_base} + (DW+1)'(prod >> FR_BITS);
        assign sat  = sum[DW] ? {DW{1'b1}} : sum[DW-1:0];

        assign out_px[c] = out_q;
    end

endmodule

// File: rtl/dgam_pingpong.sv
module dgam_pingpong
    import dgam_pkg::*;
#(
    parameter int PT_BITS = 6,
    parameter int FR_BITS = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_start,
    input  logic [2:0]                 cfg_mode,
    input  logic                       mem_off,
    input  logic                       idx_wr,
    input  logic [PT_BITS-1:0]         idx_val,
    input  logic                       dat_wr,
    input  logic [PT_BITS+FR_BITS-1:0] dat_val,
    input  logic                       wr_sel,
    input  logic [2:0]                 wr_mask,
    output logic [3:0]                 lut_stat,
    input  logic                       pix_vld,
    input  logic [PT_BITS+FR_BITS-1:0] pix_r,
    input  logic [PT_BITS+FR_BITS-1:0] pix_g,
    input  logic [PT_BITS+FR_BITS-1:0] pix_b,
    output logic                       out_vld,
    output logic                       out_ok,
    output logic [PT_BITS+FR_BITS-1:0] out_r,
    output logic [PT_BITS+FR_BITS-1:0] out_g,
    output logic [PT_BITS+FR_BITS-1:0] out_b
);

    localparam int DW = PT_BITS + FR_BITS;

    mode_e                              live_mode;
    logic [NCH-1:0]                     w_chv;
    logic                               w_ram;
    logic                               w_slope;
    logic [PT_BITS-1:0]                 w_addr;
    logic [DW-1:0]                      w_data;
    logic [NCH-1:0][DW-1:0]             pix_arr;
    logic [NCH-1:0][PT_BITS-1:0]        rd_pt;
    logic [NRAM-1:0][NCH-1:0][DW-1:0]   rd_base;
    logic [NRAM-1:0][NCH-1:0][DW-1:0]   rd_slope;
    logic [NCH-1:0][DW-1:0]             out_px;

    // Committed curve: moves only on the frame-start strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            live_mode <= MD_PASS;
        else if (frame_start)
            live_mode <= mode_e'(cfg_mode);
    end

    always_comb begin
        unique case (live_mode)
            MD_RAMA: lut_stat = 4'd9;
            MD_RAMB: lut_stat = 4'd10;
            default: lut_stat = 4'd0;
        endcase
    end

    assign pix_arr[0] = pix_r;
    assign pix_arr[1] = pix_g;
    assign pix_arr[2] = pix_b;

    for (genvar c = 0; c < NCH; c++) begin : g_pt
        assign rd_pt[c] = pix_arr[c][DW-1 -: PT_BITS];
    end

    dgam_loader #(.PT_BITS(PT_BITS), .DW(DW)) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (idx_wr),
        .idx_val   (idx_val),
        .dat_wr    (dat_wr),
        .dat_val   (dat_val),
        .wr_sel    (wr_sel),
        .wr_mask   (wr_mask),
        .live_mode (live_mode),
        .w_chv     (w_chv),
        .w_ram     (w_ram),
        .w_slope   (w_slope),
        .w_addr    (w_addr),
        .w_data    (w_data)
    );

    dgam_store #(.PT_BITS(PT_BITS), .DW(DW)) u_store (
        .clk      (clk),
        .w_chv    (w_chv),
        .w_ram    (w_ram),
        .w_slope  (w_slope),
        .w_addr   (w_addr),
        .w_data   (w_data),
        .rd_pt    (rd_pt),
        .rd_base  (rd_base),
        .rd_slope (rd_slope)
    );

    dgam_eval #(.PT_BITS(PT_BITS), .FR_BITS(FR_BITS)) u_eval (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_vld   (pix_vld),
        .pix_in    (pix_arr),
        .live_mode (live_mode),
        .mem_off   (mem_off),
        .rd_base   (rd_base),
        .rd_slope  (rd_slope),
        .out_vld   (out_vld),
        .out_ok    (out_ok),
        .out_px    (out_px)
    );

    assign out_r = out_px[0];
    assign out_g = out_px[1];
    assign out_b = out_px[2];

endmodule

// File: rtl/dgam_pingpong_chk.sv
module dgam_pingpong_chk #(
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_vld,
    input logic          out_vld,
    input logic          out_ok,
    input logic [DW-1:0] out_r,
    input logic [DW-1:0] out_g,
    input logic [DW-1:0] out_b,
    input logic          frame_start,
    input logic [3:0]    lut_stat,
    input logic [2:0]    w_chv,
    input logic          w_ram,
    input logic [2:0]    live_code
);

    a_r5_result_due: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |=> ##1 out_vld);

    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld |=> ##1 !out_vld);

    a_r9_status_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (lut_stat == 4'd0) || (lut_stat == 4'd9) || (lut_stat == 4'd10));

    a_r9_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(lut_stat));

    a_r10_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_ok) |-> (out_r == '0 && out_g == '0 && out_b == '0));

    a_r7_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(w_chv));

    a_r8_live_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        (|w_chv) |-> !((live_code == 3'd3 && !w_ram) || (live_code == 3'd4 && w_ram)));

endmodule

bind dgam_pingpong dgam_pingpong_chk #(.DW(PT_BITS + FR_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_vld     (pix_vld),
    .out_vld     (out_vld),
    .out_ok      (out_ok),
    .out_r       (out_r),
    .out_g       (out_g),
    .out_b       (out_b),
    .frame_start (frame_start),
    .lut_stat    (lut_stat),
    .w_chv       (w_chv),
    .w_ram       (w_ram),
    .live_code   (live_mode)
);

// File: tb/test_dgam_pingpong.sv
module test_dgam_pingpong;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [2:0]  cfg_mode = 3'd0;
    logic        mem_off = 1'b0;
    logic        idx_wr = 1'b0;
    logic [5:0]  idx_val = 6'd0;
    logic        dat_wr = 1'b0;
    logic [11:0] dat_val = 12'd0;
    logic        wr_sel = 1'b0;
    logic [2:0]  wr_mask = 3'd7;
    logic [3:0]  lut_stat;
    logic        pix_vld = 1'b0;
    logic [11:0] pix_r = 12'd0;
    logic [11:0] pix_g = 12'd0;
    logic [11:0] pix_b = 12'd0;
    logic        out_vld;
    logic        out_ok;
    logic [11:0] out_r;
    logic [11:0] out_g;
    logic [11:0] out_b;

    int n_chk = 0;
    int n_bad = 0;
    int live_b = 0;
    int m_ptr = 0;
    int m_ph = 0;
    int mb [2][3][64];
    int md [2][3][64];

    always #2 clk = ~clk;

    dgam_pingpong i_dgam_pingpong (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cfg_mode(cfg_mode),
        .mem_off(mem_off), .idx_wr(idx_wr), .idx_val(idx_val), .dat_wr(dat_wr),
        .dat_val(dat_val), .wr_sel(wr_sel), .wr_mask(wr_mask), .lut_stat(lut_stat),
        .pix_vld(pix_vld), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .out_vld(out_vld), .out_ok(out_ok), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog R5 act=hung exp=done");
        summary();
        $finish;
    end

    task automatic chk(input bit good, input string rq, input int act, input int exp);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int expect_ch(int code, int x, int c);
        int p = x >> 6;
        int f = x & 63;
        int b;
        int d;
        int s;
        case (code)
            1: begin b = p * p; d = 2 * p + 1; end
            2: begin b = (p * p * p) >> 6; d = (((p + 1) * (p + 1) * (p + 1)) >> 6) - b; end
            3: begin b = mb[0][c][p]; d = md[0][c][p]; end
            4: begin b = mb[1][c][p]; d = md[1][c][p]; end
            default: return x;
        endcase
        s = b + ((d * f) >> 6);
        if (s > 4095) s = 4095;
        return s;
    endfunction

    task automatic set_mode(input int code, input string rq);
        int es;
        cfg_mode = 3'(code);
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
        live_b = code;
        es = (code == 3) ? 9 : (code == 4) ? 10 : 0;
        chk(lut_stat == 4'(es), rq, lut_stat, es);
    endtask

    task automatic set_idx(input int v);
        idx_wr = 1'b1;
        idx_val = 6'(v);
        tick();
        idx_wr = 1'b0;
        m_ptr = v;
        m_ph = 0;
    endtask

    task automatic word(input int v);
        int ch;
        int rm;
        bit blocked;
        dat_wr = 1'b1;
        dat_val = 12'(v);
        tick();
        dat_wr = 1'b0;
        ch = m_ph % 3;
        rm = wr_sel ? 1 : 0;
        blocked = (live_b == 3 && rm == 0) || (live_b == 4 && rm == 1);
        if (!blocked && wr_mask[ch]) begin
            if (m_ph >= 3) md[rm][ch][m_ptr] = v;
            else mb[rm][ch][m_ptr] = v;
        end
        m_ph++;
        if (m_ph == 6) begin
            m_ph = 0;
            m_ptr = (m_ptr + 1) % 64;
        end
    endtask

    task automatic px(input int r, input int g, input int b, input string rq);
        int ex [3];
        int ac [3];
        int ok_e;
        pix_r = 12'(r); pix_g = 12'(g); pix_b = 12'(b);
        pix_vld = 1'b1;
        ok_e = (mem_off && (live_b == 3 || live_b == 4)) ? 0 : 1;
        ex[0] = expect_ch(live_b, r, 0);
        ex[1] = expect_ch(live_b, g, 1);
        ex[2] = expect_ch(live_b, b, 2);
        if (ok_e == 0) begin ex[0] = 0; ex[1] = 0; ex[2] = 0; end
        tick();
        pix_vld = 1'b0;
        chk(out_vld == 1'b0, "R5 early", out_vld, 0);
        tick();
        chk(out_vld == 1'b1, "R5 due", out_vld, 1);
        chk(out_ok == 1'(ok_e), {rq, " ok"}, out_ok, ok_e);
        ac[0] = out_r; ac[1] = out_g; ac[2] = out_b;
        for (int c = 0; c < 3; c++)
            chk(ac[c] == ex[c], rq, ac[c], ex[c]);
    endtask

    task automatic rnd_px(input int n, input string rq);
        for (int i = 0; i < n; i++)
            px($urandom % 4096, $urandom % 4096, $urandom % 4096, rq);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int r = 0; r < 2; r++)
            for (int c = 0; c < 3; c++)
                for (int p = 0; p < 64; p++) begin
                    mb[r][c][p] = 0;
                    md[r][c][p] = 0;
                end

        // R1: reset state
        repeat (3) tick();
        chk(out_vld == 1'b0, "R1 vld", out_vld, 0);
        chk(out_ok == 1'b0, "R1 ok", out_ok, 0);
        chk(out_r == 0 && out_g == 0 && out_b == 0, "R1 data", out_r, 0);
        chk(lut_stat == 4'd0, "R1 stat", lut_stat, 0);
        rst_n = 1'b1;
        tick();

        // R2: pass-through after reset and with an unused code
        px(0, 4095, 1234, "R2 pass");
        rnd_px(8, "R2 pass");
        set_mode(6, "R9 stat code6");
        rnd_px(6, "R2 code6");

        // R3/R4: built-in curves, including end points
        set_mode(1, "R9 stat curve1");
        px(4095, 0, 63, "R3 curve1 ends");
        rnd_px(15, "R3 curve1");
        set_mode(2, "R9 stat curve2");
        px(4095, 0, 64, "R3 curve2 ends");
        rnd_px(15, "R3 curve2");

        // R6/R7: full load of memory A, then commit it
        wr_sel = 1'b0; wr_mask = 3'd7;
        set_idx(0);
        for (int i = 0; i < 384; i++) word($urandom % 4096);
        set_mode(3, "R9 stat A");
        rnd_px(20, "R6 memA");

        // R8: words aimed at live memory A are discarded
        set_idx(5);
        for (int i = 0; i < 6; i++) word(4000 - i);
        px((5 << 6) | 17, (5 << 6) | 40, (5 << 6) | 63, "R8 live guard");

        // R7: load memory B while A is live
        wr_sel = 1'b1;
        set_idx(0);
        for (int i = 0; i < 384; i++) word($urandom % 4096);

        // R9: a mode request without the strobe has no effect
        cfg_mode = 3'd4;
        repeat (3) tick();
        chk(lut_stat == 4'd9, "R9 no strobe", lut_stat, 9);
        px((9 << 6) | 33, (21 << 6) | 5, (60 << 6) | 62, "R9 still A");
        set_mode(4, "R9 stat B");
        rnd_px(20, "R7 memB");

        // R7: masked write into A (green only) at point 7
        wr_sel = 1'b0; wr_mask = 3'b010;
        set_idx(7);
        for (int i = 0; i < 6; i++) word(100 + 300 * i);
        wr_mask = 3'd7;

        // R6: restart by index, index priority, pointer wrap, into A
        set_idx(20);
        for (int i = 0; i < 3; i++) word(11 + i);
        set_idx(30);
        for (int i = 0; i < 6; i++) word(700 + 50 * i);
        idx_wr = 1'b1; idx_val = 6'd40; dat_wr = 1'b1; dat_val = 12'd3333;
        tick();
        idx_wr = 1'b0; dat_wr = 1'b0;
        m_ptr = 40; m_ph = 0;
        for (int i = 0; i < 6; i++) word(1500 + 7 * i);
        set_idx(63);
        for (int i = 0; i < 12; i++) word(2000 + 90 * i);

        // R4: saturation at point 10
        set_idx(10);
        for (int i = 0; i < 6; i++) word(4095);

        set_mode(3, "R9 stat A again");
        px((7 << 6) | 32, (7 << 6) | 32, (7 << 6) | 32, "R7 mask");
        px((20 << 6) | 9, (30 << 6) | 50, (40 << 6) | 63, "R6 restart");
        px((63 << 6) | 63, (0 << 6) | 31, (63 << 6) | 1, "R6 wrap");
        px((10 << 6) | 63, (10 << 6) | 0, (10 << 6) | 1, "R4 saturate");

        // R10: memory powered down
        mem_off = 1'b1;
        rnd_px(4, "R10 off A");
        set_mode(0, "R9 stat pass");
        rnd_px(3, "R10 off pass");
        set_mode(4, "R9 stat B again");
        rnd_px(3, "R10 off B");
        mem_off = 1'b0;
        rnd_px(5, "R10 on B");

        summary();
        $finish;
    end

endmodule